// File: doc/BRIEF.md
# Paged Memory Address Translator

This block sits between a CPU and its memory system. It turns every 16-bit virtual address into a 22-bit physical address by way of a set of page relocation registers. The three high address bits choose one of eight pages, and the low thirteen bits pass through as the byte offset. Each page has a relocation word, called the base register here. The base register times 64, plus the offset, gives the physical address.

There are sixteen register pairs, each made of a base register and a descriptor register. Entries 0 to 7 serve the supervisor (kernel) context and entries 8 to 15 serve the user context. The context comes from a pair of mode bits in the processor status word. A separate access flag selects a second pair of mode bits, the previous-mode field, so that the CPU can reach memory through the other context's map. Every translated memory write marks the descriptor of its page as written.

The topmost 8 KB of virtual space is never translated. It is flagged as an I/O-page access and is mapped to the top of physical space. The CPU reads and writes the registers through a simple strobe port at fixed I/O-page word addresses. A read-only status word at its own address reports the current context and the page of the program counter.

Top module: `pmx_xlate`

## Requirements
- R1: The page index is cpu_vaddr[15:13] and the byte offset is cpu_vaddr[12:0]. The translation entry is {context, page}, where context is 1 for user.
- R2: For a translated access, mem_paddr = (base × 64 + offset) mod 2^22. The wrap-around holds even for base 16'hFFFF.
- R3: The register map uses byte addresses, and bit 0 of the byte address is ignored, so an odd byte address reaches the same register. Supervisor descriptor i is at 16'hF4C0 + 2i and supervisor base i is at 16'hF4E0 + 2i. User descriptor i is at 16'hFF80 + 2i and user base i is at 16'hFFA0 + 2i. reg_waddr carries byte-address bits 15:1.
- R4: mode_bits carries status bits 15:12. The user context is used when bits 15:14 are both 1. When cpu_prev is high, bits 13:12 decide instead. Any other value selects the supervisor context.
- R5: After reset, base register i holds (i mod 8) × 128, which is an identity map. Every descriptor holds 16'h8006: field 3 in bits 2:1 and 128 in bits 15:8.
- R6: reg_rdata and reg_hit are combinational while reg_rd is high and the address is mapped. They are 0 when reg_rd is low or the address is unmapped. A register write takes effect at the clock edge on which reg_wr is high.
- R7: A translated memory write (cpu_req and cpu_wr high, not I/O page) sets bit 6 of the descriptor of the entry it uses, at that clock edge. No other register changes, and reads set nothing.
- R8: An access with cpu_vaddr ≥ 16'hE000 raises io_sel and keeps mem_req and mem_wr low. mem_paddr = {6'h3F, cpu_vaddr}, and no written bit is set.
- R9: The status word at byte address 16'hFF7A reads bits 6:5 as 11 in the current user context and 00 in the supervisor context. Bits 3:1 hold pc_page and all other bits are 0. Writes to it are ignored.
- R10: mem_byte follows cpu_byte. For a translated request, mem_req is high and mem_wr follows cpu_wr.
- R11: When a register write to a descriptor and a memory write that marks the same descriptor fall on the same edge, the descriptor takes the written data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU access valid |
| cpu_wr | input | 1 | Access is a write |
| cpu_byte | input | 1 | Byte access flag |
| cpu_prev | input | 1 | Use the previous-mode field |
| cpu_vaddr | input | 16 | Virtual byte address |
| mode_bits | input | 4 | Status word bits 15:12 |
| pc_page | input | 3 | Program counter bits 15:13 |
| mem_req | output | 1 | Translated memory request |
| mem_wr | output | 1 | Translated memory write |
| mem_byte | output | 1 | Byte flag to memory |
| io_sel | output | 1 | Access targets the I/O page |
| mem_paddr | output | 22 | Physical byte address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 15 | Register byte address bits 15:1 |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| reg_hit | output | 1 | Read address is mapped |

## Verification
A corrupted base register, or a wrong bank choice, shows on mem_paddr in the same cycle as the access. The high bits of the address then point at the wrong 8 KB frame, while the offset bits stay correct. A written bit that is lost or set on the wrong entry stays hidden until the descriptor is read back, one cycle after the write edge at the earliest. For that reason the bench reads back the entry it touched and also a neighbour in the other bank. A decode fault in the register map shows as the wrong value, or as a missing reg_hit, on the very read strobe that addresses it.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int PMX_VA_W       = 16;
  localparam int PMX_PA_W       = 22;
  localparam int PMX_PAGES      = 8;
  localparam int PMX_REG_W      = 16;
  localparam int PMX_PAGE_BYTES = 1 << (PMX_VA_W - $clog2(PMX_PAGES));
  localparam int PMX_SCALE_SH   = 6;
  localparam int PMX_WRITTEN    = 6;
  localparam logic [PMX_REG_W-1:0] PMX_PDR_RST =
    PMX_REG_W'((3 << 1) | ((PMX_PAGE_BYTES >> PMX_SCALE_SH) << 8));

  // decode select bit positions
  localparam int SEL_KPDR = 0;
  localparam int SEL_KPAR = 1;
  localparam int SEL_UPDR = 2;
  localparam int SEL_UPAR = 3;
  localparam int SEL_SR0  = 4;
  localparam int SEL_N    = 5;

  function automatic logic [PMX_REG_W-1:0] pmx_par_rst(input int idx);
    return PMX_REG_W'((idx % PMX_PAGES) * (PMX_PAGE_BYTES >> PMX_SCALE_SH));
  endfunction

  function automatic logic pmx_is_user(input logic [3:0] mode, input logic prev);
    return prev ? (mode[1] & mode[0]) : (mode[3] & mode[2]);
  endfunction

  function automatic logic [PMX_PA_W-1:0] pmx_phys(
    input logic [PMX_REG_W-1:0] base,
    input logic [PMX_VA_W-$clog2(PMX_PAGES)-1:0] off);
    return PMX_PA_W'({base, {PMX_SCALE_SH{1'b0}}}) + PMX_PA_W'(off);
  endfunction

  function automatic logic [PMX_REG_W-1:0] pmx_sr0(input logic user,
                                                   input logic [2:0] page);
    return {9'd0, user, user, 1'b0, page, 1'b0};
  endfunction
endpackage

// File: rtl/pmx_decode.sv
module pmx_decode
  import pmx_pkg::*;
#(
  parameter int WA_W   = PMX_VA_W - 1,
  parameter int PAGES  = PMX_PAGES,
  parameter logic [WA_W-1:0] KPDR_W = 15'h7A60,
  parameter logic [WA_W-1:0] KPAR_W = 15'h7A70,
  parameter logic [WA_W-1:0] UPDR_W = 15'h7FC0,
  parameter logic [WA_W-1:0] UPAR_W = 15'h7FD0,
  parameter logic [WA_W-1:0] SR0_W  = 15'h7FBD
) (
  input  logic [WA_W-1:0]          waddr,
  output logic [SEL_N-1:0]         sel,
  output logic [$clog2(PAGES)-1:0] idx
);
  localparam int PG_W = $clog2(PAGES);

  logic [WA_W-1:0] bases [4];
  assign bases[0] = KPDR_W;
  assign bases[1] = KPAR_W;
  assign bases[2] = UPDR_W;
  assign bases[3] = UPAR_W;

  for (genvar g = 0; g < 4; g++) begin : g_win
    assign sel[g] = (waddr[WA_W-1:PG_W] == bases[g][WA_W-1:PG_W]);
  end
  assign sel[SEL_SR0] = (waddr == SR0_W);
  assign idx = waddr[PG_W-1:0];
endmodule

// File: rtl/pmx_regbank.sv
module pmx_regbank
  import pmx_pkg::*;
#(
  parameter int PAGES = PMX_PAGES,
  parameter int REG_W = PMX_REG_W,
  localparam int NREG  = 2 * PAGES,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_par,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic [IDX_W-1:0] xl_idx,
  output logic [REG_W-1:0] xl_par,
  input  logic [IDX_W-1:0] rg_idx,
  output logic [REG_W-1:0] rg_par,
  output logic [REG_W-1:0] rg_pdr
);
  logic [REG_W-1:0] par_q [NREG];
  logic [REG_W-1:0] pdr_q [NREG];
  logic             pdr_collide;

  assign pdr_collide = wr_en && !wr_par && (wr_idx == mark_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        par_q[i] <= pmx_par_rst(i);
        pdr_q[i] <= PMX_PDR_RST;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && wr_par && wr_idx == IDX_W'(i))
          par_q[i] <= wr_data;
        if (wr_en && !wr_par && wr_idx == IDX_W'(i))
          pdr_q[i] <= wr_data;
        else if (mark_en && mark_idx == IDX_W'(i))
          pdr_q[i][PMX_WRITTEN] <= 1'b1;
      end
    end
  end

  assign xl_par = par_q[xl_idx];
  assign rg_par = par_q[rg_idx];
  assign rg_pdr = pdr_q[rg_idx];

  // R7
  written_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !pdr_collide) |=> pdr_q[$past(mark_idx)][PMX_WRITTEN]);

  // R11
  reg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_par) |=> pdr_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/pmx_xlate.sv
module pmx_xlate
  import pmx_pkg::*;
#(
  parameter int VA_W  = PMX_VA_W,
  parameter int PA_W  = PMX_PA_W,
  parameter int PAGES = PMX_PAGES,
  parameter int REG_W = PMX_REG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_wr,
  input  logic            cpu_byte,
  input  logic            cpu_prev,
  input  logic [VA_W-1:0] cpu_vaddr,
  input  logic [3:0]      mode_bits,
  input  logic [2:0]      pc_page,
  output logic            mem_req,
  output logic            mem_wr,
  output logic            mem_byte,
  output logic            io_sel,
  output logic [PA_W-1:0] mem_paddr,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [VA_W-2:0] reg_waddr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic            reg_hit
);
  localparam int PG_W  = $clog2(PAGES);
  localparam int OFF_W = VA_W - PG_W;
  localparam int IDX_W = PG_W + 1;

  // translation path
  logic             xl_user, io_page, mark_en;
  logic [IDX_W-1:0] xl_idx;
  logic [REG_W-1:0] xl_par;

  assign xl_user  = pmx_is_user(mode_bits, cpu_prev);
  assign io_page  = &cpu_vaddr[VA_W-1:OFF_W];
  assign xl_idx   = {xl_user, cpu_vaddr[VA_W-1:OFF_W]};
  assign io_sel   = cpu_req & io_page;
  assign mem_req  = cpu_req & ~io_page;
  assign mem_wr   = mem_req & cpu_wr;
  assign mem_byte = cpu_byte;
  assign mark_en  = mem_wr;
  assign mem_paddr = io_page ? {{(PA_W-VA_W){1'b1}}, cpu_vaddr}
                             : pmx_phys(xl_par, cpu_vaddr[OFF_W-1:0]);

  // register access path
  logic [SEL_N-1:0] dsel;
  logic [PG_W-1:0]  didx;
  logic             d_map, d_par, d_user, d_sr0, wr_en;
  logic [REG_W-1:0] rg_par, rg_pdr, sr0_val;

  pmx_decode #(.WA_W(VA_W-1), .PAGES(PAGES)) u_dec (
    .waddr (reg_waddr),
    .sel   (dsel),
    .idx   (didx)
  );

  assign d_map  = |dsel[SEL_UPAR:SEL_KPDR];
  assign d_par  = dsel[SEL_KPAR] | dsel[SEL_UPAR];
  assign d_user = dsel[SEL_UPDR] | dsel[SEL_UPAR];
  assign d_sr0  = dsel[SEL_SR0];
  assign wr_en  = reg_wr & d_map;
  assign sr0_val = pmx_sr0(pmx_is_user(mode_bits, 1'b0), pc_page);

  pmx_regbank #(.PAGES(PAGES), .REG_W(REG_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_par   (d_par),
    .wr_idx   ({d_user, didx}),
    .wr_data  (reg_wdata),
    .mark_en  (mark_en),
    .mark_idx (xl_idx),
    .xl_idx   (xl_idx),
    .xl_par   (xl_par),
    .rg_idx   ({d_user, didx}),
    .rg_par   (rg_par),
    .rg_pdr   (rg_pdr)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (d_sr0)      reg_rdata = sr0_val;
      else if (d_par) reg_rdata = rg_par;
      else if (d_map) reg_rdata = rg_pdr;
    end
  end
  assign reg_hit = reg_rd & (d_map | d_sr0);

  // R8
  io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (!mem_req && !mem_wr));

  // R6
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0 && !reg_hit));

  // R3
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dsel));

  // R9
  sr0_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && d_sr0) |-> (reg_rdata[6] == reg_rdata[5] && reg_rdata[15:7] == '0));
endmodule

// File: tb/sim_pmx_xlate.sv
module sim_pmx_xlate;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 0, cpu_wr = 0, cpu_byte = 0, cpu_prev = 0;
  logic [15:0] cpu_vaddr = '0;
  logic [3:0]  mode_bits = '0;
  logic [2:0]  pc_page = '0;
  logic        mem_req, mem_wr, mem_byte, io_sel, reg_hit;
  logic [21:0] mem_paddr;
  logic        reg_rd = 0, reg_wr = 0;
  logic [14:0] reg_waddr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;

  pmx_xlate u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct { int kind; int expv; string req; } item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int m_par [16];
  int m_pdr [16];

  function automatic int observe(int kind);
    case (kind)
      0: return int'(mem_paddr);
      1: return int'(reg_rdata);
      2: return int'(io_sel);
      3: return int'(mem_req);
      4: return int'(mem_wr);
      5: return int'(mem_byte);
      default: return int'(reg_hit);
    endcase
  endfunction

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      int got;
      it = sbq.pop_front();
      got = observe(it.kind);
      n_cmp++;
      if (got !== it.expv) begin
        n_bad++;
        $display("FAIL %s kind%0d actual=%h expected=%h", it.req, it.kind, got, it.expv);
      end
    end
  end

  task automatic push(int kind, int expv, string req);
    item_t it;
    it.kind = kind; it.expv = expv; it.req = req;
    sbq.push_back(it);
  endtask

  function automatic int ref_addr(int bank, int i, bit par);
    int base;
    base = (bank == 0) ? (par ? 'hF4E0 : 'hF4C0) : (par ? 'hFFA0 : 'hFF80);
    return base + i * 2;
  endfunction

  function automatic int ref_phys(int base, int va);
    return (base * 64 + (va % 8192)) % (1 << 22);
  endfunction

  function automatic bit ref_user(int mode, bit prev);
    return prev ? ((mode % 4) == 3) : ((mode / 4) == 3);
  endfunction

  task automatic go_idle();
    @(posedge clk); #1;
    cpu_req = 0; cpu_wr = 0; cpu_prev = 0; cpu_byte = 0;
    reg_rd = 0; reg_wr = 0;
  endtask

  task automatic rd_reg(int baddr, int expv, string req);
    @(posedge clk); #1;
    reg_rd = 1; reg_waddr = 15'(baddr >> 1);
    push(1, expv, req); push(6, 1, req);
    go_idle();
  endtask

  task automatic wr_reg(int baddr, int data);
    @(posedge clk); #1;
    reg_wr = 1; reg_waddr = 15'(baddr >> 1); reg_wdata = 16'(data);
    go_idle();
  endtask

  task automatic access(int va, int mode, bit prev, bit wr, bit byt, string req);
    int ent;
    bit io;
    @(posedge clk); #1;
    cpu_req = 1; cpu_vaddr = 16'(va); mode_bits = 4'(mode);
    cpu_prev = prev; cpu_wr = wr; cpu_byte = byt;
    io = (va >= 'hE000);
    ent = (ref_user(mode, prev) ? 8 : 0) + va / 8192;
    push(0, io ? ('h3F0000 + va) : ref_phys(m_par[ent], va), req);
    push(2, int'(io), req);
    push(3, int'(!io), req);
    push(4, int'(!io && wr), req);
    push(5, int'(byt), req);
    go_idle();
    if (wr && !io) m_pdr[ent] = m_pdr[ent] | 'h40;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_par[i] = (i & 7) << 7;
      m_pdr[i] = 'h8006;
    end
    #(PERIOD * 3) rst_n = 1;

    // R5 R3: reset contents of both banks
    for (int i = 0; i < 16; i++) begin
      rd_reg(ref_addr(i / 8, i % 8, 1), m_par[i], "R5");
      rd_reg(ref_addr(i / 8, i % 8, 0), m_pdr[i], "R5");
    end

    // R1 R2 R10: supervisor identity map, word and byte
    access('h1234, 0, 0, 0, 0, "R1");
    access('h5FFE, 0, 0, 0, 1, "R10");

    // R6 R3: write a user base register, read back at even and odd byte address
    wr_reg(ref_addr(1, 3, 1), 'h0ABC);
    m_par[11] = 'h0ABC;
    rd_reg(ref_addr(1, 3, 1), 'h0ABC, "R6");
    rd_reg(ref_addr(1, 3, 1) + 1, 'h0ABC, "R3");
    rd_reg(ref_addr(0, 3, 1), m_par[3], "R3");

    // R4: context selection from mode bits and previous-mode flag
    access('h6010, 'hC, 0, 0, 0, "R4");
    access('h6010, 'h8, 0, 0, 0, "R4");
    access('h6010, 'h3, 1, 0, 0, "R4");
    access('h6010, 'h3, 0, 0, 0, "R4");

    // R7: written bit only on the entry used, reads mark nothing
    access('h6020, 'hC, 0, 1, 0, "R7");
    rd_reg(ref_addr(1, 3, 0), 'h8046, "R7");
    rd_reg(ref_addr(0, 3, 0), 'h8006, "R7");
    access('h4000, 0, 0, 0, 0, "R7");
    rd_reg(ref_addr(0, 2, 0), 'h8006, "R7");

    // R8: I/O page read and write bypass translation
    access('hE010, 0, 0, 0, 0, "R8");
    access('hFFFE, 'hC, 0, 1, 1, "R8");
    rd_reg(ref_addr(0, 7, 0), 'h8006, "R8");
    rd_reg(ref_addr(1, 7, 0), 'h8006, "R8");

    // R9: status word, current context and pc page
    @(posedge clk); #1; mode_bits = 'hC; pc_page = 5;
    rd_reg('hFF7A, 'h006A, "R9");
    @(posedge clk); #1; mode_bits = 'h3; pc_page = 1;
    rd_reg('hFF7A, 'h0002, "R9");
    wr_reg('hFF7A, 'hFFFF);
    rd_reg('hFF7A, 'h0002, "R9");

    // R6: unmapped address and no strobe give zero
    @(posedge clk); #1;
    reg_rd = 1; reg_waddr = 15'('hFF70 >> 1);
    push(1, 0, "R6"); push(6, 0, "R6");
    go_idle();
    @(posedge clk); #1;
    reg_waddr = 15'(ref_addr(1, 3, 1) >> 1);
    push(1, 0, "R6"); push(6, 0, "R6");
    go_idle();

    // R2: wrap-around with the largest base
    wr_reg(ref_addr(0, 1, 1), 'hFFFF);
    m_par[1] = 'hFFFF;
    access('h3FFF, 0, 0, 0, 0, "R2");

    // R11: register write and mark on the same descriptor
    @(posedge clk); #1;
    cpu_req = 1; cpu_wr = 1; cpu_vaddr = 'h6000; mode_bits = 'hC; cpu_prev = 0;
    reg_wr = 1; reg_waddr = 15'(ref_addr(1, 3, 0) >> 1); reg_wdata = 'h1234;
    go_idle();
    rd_reg(ref_addr(1, 3, 0), 'h1234, "R11");

    @(posedge clk); @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule